// File: doc/BRIEF.md
# Channel Limit and Fault Monitor

This block guards a set of monitored analog channels. Each channel has four programmable 16-bit limit words. The first two are under-limits and the last two are over-limits. Every incoming 10-bit sample is compared against the four limits of its channel. A violation sets a sticky per-channel fault flag. The flags are presented to software as two byte-wide status registers, and reading a status byte clears it.

The top four bits of each limit word carry trigger-action flags:

| Bit | Meaning |
|-----|---------|
| 15 | reset request |
| 14 | healthy marker |
| 13 | power-off request |
| 12 | shutdown request |

The block reports one critical flag per limit. It also drives three summary requests (reset, power-off, shutdown) taken from the limits that the latest sample of each channel violated.

Access uses a byte-wide register port with two banks. Bank 0 holds the limit words and bank 1 holds the status bytes. Register reads are combinational.

Top module: `limit_fault_monitor`

## Requirements
- R1: After reset, all limit bytes read 0, both status bytes read 0, every critical flag is 0, and all three request outputs are 0.
- R2: In bank 0, limit L (0..3) of channel C sits at byte address 0x80 + 8*C + 2*L (high byte) and the next address (low byte). Writes to these bytes read back unchanged.
- R3: When an enabled under-limit (L = 0 or 1) has a threshold in bits 9..0 and a sample is strictly below that threshold, the channel's fault flag sets. A sample equal to the threshold sets nothing.
- R4: A sample strictly above the threshold of an enabled over-limit (L = 2 or 3) sets the channel's fault flag. A sample equal to the threshold sets nothing.
- R5: A limit word of all zeros is disabled and never causes a violation. Any non-zero word, including one with only action bits set, is enabled.
- R6: Channel 8 compares as 10-bit two's complement (codes above 511 are negative). All other channels compare unsigned.
- R7: In bank 1, address 0x81 returns fault bits 15..8 and address 0x82 returns fault bits 7..0. Fault bit N belongs to channel N for N = 0..10, and unused bits read 0.
- R8: A fault flag stays set until its status byte is read with the read strobe. Reading one status byte leaves the other byte's flags untouched. A set in the same cycle as a clear wins.
- R9: The critical flag of limit L of channel C is at index 4*C + L. It is 1 exactly when bit 15, 13 or 12 of that limit word is set. Bit 14 alone does not make a limit critical.
- R10: Each request output is the OR, over all limits that the latest sample of their channel violated, of that limit's matching action bit (reset = 15, power-off = 13, shutdown = 12). A later in-range sample of the channel drops its contribution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Byte write strobe |
| reg_rd | input | 1 | Byte read strobe (clears status on read) |
| reg_bank | input | 1 | 0 = limit bank, 1 = status bank |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| smp_valid | input | 1 | Sample strobe |
| smp_ch | input | 4 | Sample channel number |
| smp_data | input | 10 | Sample value |
| lim_critical | output | 44 | Critical flag per limit |
| req_reset | output | 1 | Reset request summary |
| req_poweroff | output | 1 | Power-off request summary |
| req_shutdown | output | 1 | Shutdown request summary |

## Verification
A sample or limit write presented before a rising edge is registered at that edge. The fault flags and request outputs change in the following cycle, and the bench samples them at the next falling edge. Read data is combinational, so the bench captures it one nanosecond after it drives the address. The read-side clear takes effect at the following rising edge, and a second read confirms it. Critical flags follow a limit write after one edge and are checked at the falling edge after that write.

// File: rtl/limit_fault_monitor.sv
module limit_fault_monitor #(
  parameter int NCH = 11,
  parameter int NLIM = 4,
  parameter int TW = 10,
  parameter int TEMP_CH = 8,
  parameter int CHW = 4,
  parameter logic [7:0] LIM_BASE = 8'h80,
  parameter logic [7:0] STS_HI = 8'h81,
  parameter logic [7:0] STS_LO = 8'h82
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_bank,
  input  logic [7:0]           reg_addr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic                 smp_valid,
  input  logic [CHW-1:0]       smp_ch,
  input  logic [TW-1:0]        smp_data,
  output logic [NCH*NLIM-1:0]  lim_critical,
  output logic                 req_reset,
  output logic                 req_poweroff,
  output logic                 req_shutdown
);
  localparam int NL = NCH * NLIM;
  localparam int NB = NL * 2;

  logic [15:0]     lim_q [NL];
  logic [NL-1:0]   viol_q;
  logic [NCH-1:0]  fault_q;
  logic [15:0]     fault16;
  logic [7:0]      off;
  logic            lim_hit, ch_ok, rd_hi, rd_lo;
  int              lidx, base;
  logic [NLIM-1:0] viol_now;
  logic [NCH-1:0]  fset, fclr;
  logic [NL-1:0]   act_rst, act_pof, act_sdn;

  assign off     = reg_addr - LIM_BASE;
  assign lim_hit = !reg_bank && (reg_addr >= LIM_BASE) && (int'(off) < NB);
  assign lidx    = lim_hit ? int'(off[7:1]) : 0;
  assign fault16 = {{(16-NCH){1'b0}}, fault_q};
  assign ch_ok   = int'(smp_ch) < NCH;
  assign base    = ch_ok ? int'(smp_ch) * NLIM : 0;
  assign rd_hi   = reg_rd && reg_bank && (reg_addr == STS_HI);
  assign rd_lo   = reg_rd && reg_bank && (reg_addr == STS_LO);

  always_comb begin
    reg_rdata = '0;
    if (reg_bank) begin
      if (reg_addr == STS_HI)      reg_rdata = fault16[15:8];
      else if (reg_addr == STS_LO) reg_rdata = fault16[7:0];
    end else if (lim_hit) begin
      reg_rdata = off[0] ? lim_q[lidx][7:0] : lim_q[lidx][15:8];
    end
  end

  always_comb begin
    for (int l = 0; l < NLIM; l++) begin
      logic [15:0] w;
      logic lt, gt;
      w = lim_q[base + l];
      if (int'(smp_ch) == TEMP_CH) begin
        lt = $signed(smp_data) < $signed(w[TW-1:0]);
        gt = $signed(smp_data) > $signed(w[TW-1:0]);
      end else begin
        lt = smp_data < w[TW-1:0];
        gt = smp_data > w[TW-1:0];
      end
      viol_now[l] = (|w) && ((l < NLIM/2) ? lt : gt);
    end
  end

  assign fset = (smp_valid && ch_ok && |viol_now) ? ({{(NCH-1){1'b0}}, 1'b1} << smp_ch) : '0;

  always_comb begin
    for (int b = 0; b < NCH; b++)
      fclr[b] = (b < 8) ? rd_lo : rd_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) lim_q[i] <= '0;
      viol_q  <= '0;
      fault_q <= '0;
    end else begin
      if (reg_wr && lim_hit) begin
        if (off[0]) lim_q[lidx][7:0]  <= reg_wdata;
        else        lim_q[lidx][15:8] <= reg_wdata;
      end
      if (smp_valid && ch_ok) begin
        for (int i = 0; i < NL; i++)
          if (i / NLIM == int'(smp_ch)) viol_q[i] <= viol_now[i % NLIM];
      end
      fault_q <= (fault_q & ~fclr) | fset;
    end
  end

  always_comb begin
    for (int i = 0; i < NL; i++) begin
      act_rst[i]      = lim_q[i][15];
      act_pof[i]      = lim_q[i][13];
      act_sdn[i]      = lim_q[i][12];
      lim_critical[i] = lim_q[i][15] | lim_q[i][13] | lim_q[i][12];
    end
  end

  assign req_reset    = |(viol_q & act_rst);
  assign req_poweroff = |(viol_q & act_pof);
  assign req_shutdown = |(viol_q & act_sdn);

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_bank) |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R8
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !reg_rd) |=> $stable(fault_q)); // R8
  AST_LO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !smp_valid) |=> (fault16[7:0] == 8'h00)); // R8
  AST_SET_ON_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && ch_ok && |viol_now) |=> fault_q[$past(smp_ch)]); // R3
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_reset) || $rose(req_poweroff) || $rose(req_shutdown)) |-> ($past(smp_valid) || $past(reg_wr))); // R10
endmodule

// File: tb/test_limit_fault_monitor.sv
`timescale 1ns/1ps
module test_limit_fault_monitor;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_bank = 0;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic smp_valid = 0;
  logic [3:0] smp_ch = 0;
  logic [9:0] smp_data = 0;
  logic [43:0] lim_critical;
  logic req_reset, req_poweroff, req_shutdown;
  int n_run = 0, n_fail = 0;
  logic done = 0;

  always #5 clk = ~clk;

  limit_fault_monitor i_limit_fault_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_bank(reg_bank),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_data(smp_data),
    .lim_critical(lim_critical), .req_reset(req_reset),
    .req_poweroff(req_poweroff), .req_shutdown(req_shutdown));

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(logic [7:0] a, logic [7:0] d);
    @(negedge clk); reg_bank = 0; reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic set_lim(int ch, int l, logic [15:0] w);
    wr_byte(8'(8'h80 + 8*ch + 2*l), w[15:8]);
    wr_byte(8'(8'h81 + 8*ch + 2*l), w[7:0]);
  endtask

  task automatic rd_byte(logic bank, logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_bank = bank; reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0; reg_bank = 0;
  endtask

  task automatic sample(int ch, logic [9:0] v);
    @(negedge clk); smp_ch = 4'(ch); smp_data = v; smp_valid = 1;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd_byte(1, 8'h81, d); check("R1 status hi", d, 0);
    rd_byte(1, 8'h82, d); check("R1 status lo", d, 0);
    rd_byte(0, 8'hD7, d); check("R1 limit byte", d, 0);
    check("R1 critical", int'(lim_critical != 0), 0);
    check("R1 requests", {req_reset, req_poweroff, req_shutdown}, 0);
  endtask

  task automatic t_storage;
    logic [7:0] d;
    set_lim(3, 2, 16'hA1F3);
    rd_byte(0, 8'h9C, d); check("R2 high byte", d, 8'hA1);
    rd_byte(0, 8'h9D, d); check("R2 low byte", d, 8'hF3);
    rd_byte(0, 8'h9E, d); check("R2 neighbour untouched", d, 0);
    set_lim(3, 2, 16'h0000);
  endtask

  task automatic t_under;
    logic [7:0] d;
    set_lim(0, 0, 16'h0100);
    sample(0, 10'd256);
    rd_byte(1, 8'h82, d); check("R3 equal no fault", d, 0);
    sample(0, 10'd255);
    rd_byte(1, 8'h82, d); check("R3 below sets bit0", d, 8'h01);
    rd_byte(1, 8'h82, d); check("R8 cleared by read", d, 0);
  endtask

  task automatic t_over;
    logic [7:0] d;
    set_lim(9, 3, 16'h0200);
    set_lim(0, 1, 16'h0050);
    sample(9, 10'd512);
    rd_byte(1, 8'h81, d); check("R4 equal no fault", d, 0);
    sample(9, 10'd513);
    sample(0, 10'd16);
    rd_byte(1, 8'h82, d); check("R7 lo byte ch0", d, 8'h01);
    rd_byte(1, 8'h81, d); check("R8 hi kept after lo read, R4 ch9", d, 8'h02);
    rd_byte(1, 8'h81, d); check("R8 hi cleared", d, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] d;
    sample(5, 10'd0);
    sample(5, 10'd1023);
    set_lim(6, 0, 16'h8000);
    sample(6, 10'd0);
    rd_byte(1, 8'h82, d); check("R5 disabled/zero-thr no fault", d, 0);
    check("R5 no request", req_reset, 0);
  endtask

  task automatic t_temp;
    logic [7:0] d;
    set_lim(8, 2, 16'h03F0);
    sample(8, 10'd5);
    rd_byte(1, 8'h81, d); check("R6 signed over (5 > -16)", d, 8'h01);
    set_lim(8, 2, 16'h0000);
    set_lim(8, 0, 16'h0004);
    sample(8, 10'h3FF);
    rd_byte(1, 8'h81, d); check("R6 signed under (-1 < 4)", d, 8'h01);
    set_lim(1, 0, 16'h0004);
    sample(1, 10'h3FF);
    rd_byte(1, 8'h82, d); check("R6 unsigned other channel", d, 0);
  endtask

  task automatic t_crit;
    set_lim(2, 1, 16'h4000);
    @(negedge clk); check("R9 healthy only not critical", lim_critical[9], 0);
    set_lim(2, 1, 16'h2000);
    @(negedge clk); check("R9 power-off critical", lim_critical[9], 1);
    set_lim(2, 3, 16'h1000);
    @(negedge clk); check("R9 shutdown critical", lim_critical[11], 1);
    check("R9 index 10 clear", lim_critical[10], 0);
  endtask

  task automatic t_actions;
    set_lim(4, 0, 16'h8000 | 16'd300);
    set_lim(4, 3, 16'h1000 | 16'd400);
    sample(4, 10'd200);
    check("R10 reset req", {req_reset, req_poweroff, req_shutdown}, 3'b100);
    sample(4, 10'd500);
    check("R10 shutdown req", {req_reset, req_poweroff, req_shutdown}, 3'b001);
    sample(4, 10'd350);
    check("R10 in range drops", {req_reset, req_poweroff, req_shutdown}, 3'b000);
    set_lim(7, 1, 16'h2000 | 16'd50);
    sample(7, 10'd10);
    check("R10 power-off req", {req_reset, req_poweroff, req_shutdown}, 3'b010);
    sample(7, 10'd60);
    check("R10 power-off drops", req_poweroff, 0);
  endtask

  initial begin
    #200000000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_storage();
    t_under();
    t_over();
    t_disabled();
    t_temp();
    t_crit();
    t_actions();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule